// File: doc/BRIEF.md
# RTD Measurement Sequencer with SPI Master

This block drives a resistance-thermometer front-end converter over a four-wire serial link. It takes care of everything from the converter's configuration register to the finished result. After reset it configures the converter once. A read-modify-write of the configuration byte applies the wiring choice (3-wire or 2/4-wire) and the mains-rejection filter choice (50 Hz or 60 Hz), both taken from static inputs.

Each pulse on `meas_start` runs one full measurement in a fixed order. The sequencer switches the sensor bias on and waits for the input network to settle. It then starts a single conversion and clears the fault latch in the same write. It waits out the conversion time set by the chosen filter, fetches the two result bytes and switches the bias off. The 15-bit resistance code is then presented together with a valid flag. A pulse on `fault_start` instead fetches the fault byte and reports the over/under-voltage flag.

The serial shifting is built in. The link uses clock phase 1, MSB first, and select is held low across each multi-byte transfer. The clock idle level is a parameter, which selects between mode 1 and mode 3.

Top module: `rtd_seq_top`

## Requirements
- R1: After reset, before any trigger is served, the sequencer reads the configuration byte (address 0x00) and writes it back with bit 4 set if `cfg_three_wire` is high and bit 0 set if `cfg_filter_50` is high. All other bits are written back unchanged.
- R2: The first byte of every transfer carries the register address in bits 6:0, with bit 7 = 1 for a write and 0 for a read. Configuration is at 0x00 (one byte). The result is read from 0x01 as two bytes. Faults are read from 0x07 as one byte. `spi_cs_n` stays low for the whole transfer, is high between transfers, and is low only while `busy` is high.
- R3: A measurement is exactly seven transfers in this order. First a configuration read-modify-write that sets bit 7 (bias). Second a read-modify-write that sets bit 5 (one-shot) and bit 1 (fault clear) together in one write. Third the two-byte result read. Last a read-modify-write that clears bit 7.
- R4: At least `SETTLE_US` microseconds (`CYC_PER_US` cycles each) separate the end of the bias-on write and the start of the next transfer.
- R5: The gap between the end of the one-shot write and the start of the result read is at least `CONV50_US` when the 50 Hz filter was latched at start-up, and at least `CONV60_US` otherwise.
- R6: `rtd_code` equals the two result bytes joined first-byte-high and shifted right by one. `rtd_valid` rises at the end of the measurement and drops when the next measurement is accepted. `rtd_code` holds while valid and idle.
- R7: `busy` is high from an accepted trigger until completion. `done` is a one-cycle pulse in the cycle `busy` falls. Triggers that arrive while busy are ignored. If both triggers arrive together in idle, the measurement wins.
- R8: A fault request performs one single-byte read of address 0x07. `ovuv_fault` takes bit 2 of that byte, updated at `done`.
- R9: MOSI changes on the leading SCLK edge and MISO is sampled on the trailing edge, MSB first. SCLK rests at the `CPOL` level whenever `spi_cs_n` is high.
- R10: While `rst_n` is low, `spi_cs_n`=1, `spi_sclk`=`CPOL`, `busy`=0, `done`=0 and `rtd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_three_wire | input | 1 | Static: select 3-wire sensor connection |
| cfg_filter_50 | input | 1 | Static: select 50 Hz rejection (else 60 Hz) |
| meas_start | input | 1 | Pulse: run one measurement |
| fault_start | input | 1 | Pulse: read the fault byte |
| busy | output | 1 | Sequencer active |
| done | output | 1 | One-cycle completion pulse |
| rtd_valid | output | 1 | `rtd_code` holds a finished result |
| rtd_code | output | 15 | Resistance code |
| ovuv_fault | output | 1 | Over/under-voltage flag from the last fault read |
| spi_cs_n | output | 1 | Converter select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |

## Verification
The bench builds the block with `CYC_PER_US`=1, `SETTLE_US`=30, `CONV60_US`=50, `CONV50_US`=90, `HALF_PER`=2 and `CPOL`=0. The millisecond waits therefore shrink to tens of cycles, and a full measurement fits in under a thousand cycles. That makes many measurements possible: it lets the bench compare measured gaps against both filter bounds, and separate the 60 Hz wait from the 50 Hz one. With `CPOL`=0 the link runs in mode 1 against a behavioural converter model.

// File: rtl/rtd_seq_pkg.sv
// Shared constants and state types for the RTD measurement sequencer.
// Register addresses and bit positions follow the converter's register layout.
package rtd_seq_pkg;

    localparam logic [6:0] ADDR_CFG = 7'h00;
    localparam logic [6:0] ADDR_RTD = 7'h01;
    localparam logic [6:0] ADDR_FLT = 7'h07;

    localparam int BIT_BIAS    = 7;
    localparam int BIT_ONESHOT = 5;
    localparam int BIT_3W      = 4;
    localparam int BIT_FCLR    = 1;
    localparam int BIT_F50     = 0;
    localparam int BIT_OVUV    = 2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_INIT_RD, ST_INIT_WR, ST_BIAS_RD, ST_BIAS_WR, ST_SETTLE,
        ST_OS_RD, ST_OS_WR, ST_CONV, ST_RES_RD, ST_OFF_RD, ST_OFF_WR, ST_FLT_RD
    } step_t;

    typedef enum logic [2:0] {
        X_IDLE, X_SETUP, X_SHIFT, X_HOLD, X_GAP
    } xact_t;

endpackage

// File: rtl/rtd_spi_byte.sv
// Shifts one byte out and one byte in, MSB first, with clock phase 1:
// MOSI is updated on the leading SCLK edge and MISO is captured on the trailing edge.
// Assumes start is only pulsed while idle. SCLK rests at CPOL.
module rtd_spi_byte #(
    parameter int HALF_PER = 4,
    parameter bit CPOL     = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;

    logic [CW-1:0] div;
    logic [2:0]    bitn;
    logic          phase;
    logic          active;
    logic [7:0]    sh;

    // Half-period divider and edge generation for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div    <= '0;
            bitn   <= '0;
            phase  <= 1'b0;
            active <= 1'b0;
            sh     <= '0;
            rx     <= '0;
            done   <= 1'b0;
            sclk   <= CPOL;
            mosi   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sh     <= tx;
                    bitn   <= '0;
                    phase  <= 1'b0;
                    div    <= '0;
                end
            end else if (div != CW'(HALF_PER - 1)) begin
                div <= div + 1'b1;
            end else begin
                div <= '0;
                if (!phase) begin
                    sclk  <= ~CPOL;
                    mosi  <= sh[7];
                    phase <= 1'b1;
                end else begin
                    sclk  <= CPOL;
                    rx    <= {rx[6:0], miso};
                    sh    <= {sh[6:0], 1'b0};
                    phase <= 1'b0;
                    bitn  <= bitn + 3'd1;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtd_spi_xact.sv
// Runs one register transfer: an address byte (bit 7 = write), then one data byte
// to write or one or two bytes to read. Select is held low over all bytes, with
// HALF_PER cycles of setup, hold and gap. Read bytes collect first-high in rdata.
module rtd_spi_xact import rtd_seq_pkg::*; #(
    parameter int HALF_PER = 4,
    parameter bit CPOL     = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_write,
    input  logic [6:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        two_bytes,
    output logic        done,
    output logic [15:0] rdata,
    output logic        cs_n,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso
);
    localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;

    xact_t         xs;
    logic [CW-1:0] cnt;
    logic          wr;
    logic          first;
    logic [1:0]    nleft;
    logic [7:0]    wd;
    logic          b_start;
    logic [7:0]    b_tx;
    logic          b_done;
    logic [7:0]    b_rx;

    rtd_spi_byte #(.HALF_PER(HALF_PER), .CPOL(CPOL)) u_byte (
        .clk   (clk),
        .rst_n (rst_n),
        .start (b_start),
        .tx    (b_tx),
        .done  (b_done),
        .rx    (b_rx),
        .sclk  (sclk),
        .mosi  (mosi),
        .miso  (miso)
    );

    // Transfer framing: select, byte issue, read collection, hold and gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs      <= X_IDLE;
            cnt     <= '0;
            wr      <= 1'b0;
            first   <= 1'b0;
            nleft   <= '0;
            wd      <= '0;
            b_start <= 1'b0;
            b_tx    <= '0;
            rdata   <= '0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            b_start <= 1'b0;
            done    <= 1'b0;
            unique case (xs)
                X_IDLE: if (start) begin
                    cs_n  <= 1'b0;
                    wr    <= is_write;
                    wd    <= wdata;
                    nleft <= (two_bytes && !is_write) ? 2'd2 : 2'd1;
                    first <= 1'b1;
                    cnt   <= '0;
                    b_tx  <= {is_write, addr};
                    xs    <= X_SETUP;
                end
                X_SETUP: begin
                    if (cnt == CW'(HALF_PER - 1)) begin
                        b_start <= 1'b1;
                        xs      <= X_SHIFT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                X_SHIFT: if (b_done) begin
                    if (!first && !wr) rdata <= {rdata[7:0], b_rx};
                    if (!first && nleft == 2'd1) begin
                        cnt <= '0;
                        xs  <= X_HOLD;
                    end else begin
                        if (!first) nleft <= nleft - 2'd1;
                        first   <= 1'b0;
                        b_tx    <= wr ? wd : 8'h00;
                        b_start <= 1'b1;
                    end
                end
                X_HOLD: begin
                    if (cnt == CW'(HALF_PER - 1)) begin
                        cs_n <= 1'b1;
                        cnt  <= '0;
                        xs   <= X_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                X_GAP: begin
                    if (cnt == CW'(HALF_PER - 1)) begin
                        done <= 1'b1;
                        xs   <= X_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: xs <= X_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rtd_wait_timer.sv
// Down-counter that pulses expired no earlier than len cycles after start.
// Assumes len >= 1. A new start reloads the count.
module rtd_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;
    logic         run;

    // Load on start, count down, pulse once at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (start) begin
                cnt <= len;
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= W'(1)) begin
                    expired <= 1'b1;
                    run     <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rtd_seq_top.sv
// Measurement sequencer for a serial RTD converter. It configures wiring and filter
// once after reset. Then, per trigger, it runs bias-on, settle, one-shot with fault
// clear, conversion wait, result read and bias-off, or a single fault-byte read.
// Every configuration change is a read-modify-write. The static inputs are latched
// at start-up.
module rtd_seq_top import rtd_seq_pkg::*; #(
    parameter int CYC_PER_US = 125,
    parameter int SETTLE_US  = 10500,
    parameter int CONV50_US  = 62500,
    parameter int CONV60_US  = 52000,
    parameter int HALF_PER   = 4,
    parameter bit CPOL       = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_three_wire,
    input  logic        cfg_filter_50,
    input  logic        meas_start,
    input  logic        fault_start,
    output logic        busy,
    output logic        done,
    output logic        rtd_valid,
    output logic [14:0] rtd_code,
    output logic        ovuv_fault,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
    localparam int CONV50_CYC = CYC_PER_US * CONV50_US;
    localparam int CONV60_CYC = CYC_PER_US * CONV60_US;
    localparam int MAX_CYC    = (SETTLE_CYC > CONV50_CYC)
                              ? ((SETTLE_CYC > CONV60_CYC) ? SETTLE_CYC : CONV60_CYC)
                              : ((CONV50_CYC > CONV60_CYC) ? CONV50_CYC : CONV60_CYC);
    localparam int TW = $clog2(MAX_CYC + 1);

    step_t         step;
    logic          boot;
    logic          issued;
    logic          three_q;
    logic          f50_q;
    logic          is_xact;
    logic          x_start;
    logic          x_done;
    logic          x_write;
    logic          x_two;
    logic [6:0]    x_addr;
    logic [7:0]    x_wdata;
    logic [15:0]   x_rdata;
    logic          t_start;
    logic          t_exp;
    logic [TW-1:0] t_len;

    assign busy    = (step != ST_IDLE);
    assign is_xact = !(step inside {ST_IDLE, ST_SETTLE, ST_CONV});

    // Transfer parameters per step; writes modify the byte fetched by the prior read.
    always_comb begin
        x_write = 1'b0;
        x_two   = 1'b0;
        x_addr  = ADDR_CFG;
        x_wdata = x_rdata[7:0];
        unique case (step)
            ST_INIT_WR: begin
                x_write          = 1'b1;
                x_wdata[BIT_3W]  = x_rdata[BIT_3W] | three_q;
                x_wdata[BIT_F50] = x_rdata[BIT_F50] | f50_q;
            end
            ST_BIAS_WR: begin
                x_write           = 1'b1;
                x_wdata[BIT_BIAS] = 1'b1;
            end
            ST_OS_WR: begin
                x_write              = 1'b1;
                x_wdata[BIT_ONESHOT] = 1'b1;
                x_wdata[BIT_FCLR]    = 1'b1;
            end
            ST_OFF_WR: begin
                x_write           = 1'b1;
                x_wdata[BIT_BIAS] = 1'b0;
            end
            ST_RES_RD: begin
                x_addr = ADDR_RTD;
                x_two  = 1'b1;
            end
            ST_FLT_RD: x_addr = ADDR_FLT;
            default: ;
        endcase
    end

    rtd_spi_xact #(.HALF_PER(HALF_PER), .CPOL(CPOL)) u_xact (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (x_start),
        .is_write  (x_write),
        .addr      (x_addr),
        .wdata     (x_wdata),
        .two_bytes (x_two),
        .done      (x_done),
        .rdata     (x_rdata),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .miso      (spi_miso)
    );

    rtd_wait_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .len     (t_len),
        .expired (t_exp)
    );

    // Step sequencing, trigger acceptance and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step       <= ST_IDLE;
            boot       <= 1'b1;
            issued     <= 1'b0;
            three_q    <= 1'b0;
            f50_q      <= 1'b0;
            x_start    <= 1'b0;
            t_start    <= 1'b0;
            t_len      <= '0;
            done       <= 1'b0;
            rtd_valid  <= 1'b0;
            rtd_code   <= '0;
            ovuv_fault <= 1'b0;
        end else begin
            x_start <= 1'b0;
            t_start <= 1'b0;
            done    <= 1'b0;
            if (step == ST_IDLE) begin
                if (boot) begin
                    boot    <= 1'b0;
                    three_q <= cfg_three_wire;
                    f50_q   <= cfg_filter_50;
                    step    <= ST_INIT_RD;
                end else if (meas_start) begin
                    rtd_valid <= 1'b0;
                    step      <= ST_BIAS_RD;
                end else if (fault_start) begin
                    step <= ST_FLT_RD;
                end
            end else if (step == ST_SETTLE) begin
                if (t_exp) step <= ST_OS_RD;
            end else if (step == ST_CONV) begin
                if (t_exp) step <= ST_RES_RD;
            end else if (is_xact && !issued) begin
                x_start <= 1'b1;
                issued  <= 1'b1;
            end else if (x_done) begin
                issued <= 1'b0;
                unique case (step)
                    ST_INIT_RD: step <= ST_INIT_WR;
                    ST_INIT_WR: step <= ST_IDLE;
                    ST_BIAS_RD: step <= ST_BIAS_WR;
                    ST_BIAS_WR: begin
                        t_start <= 1'b1;
                        t_len   <= TW'(SETTLE_CYC);
                        step    <= ST_SETTLE;
                    end
                    ST_OS_RD: step <= ST_OS_WR;
                    ST_OS_WR: begin
                        t_start <= 1'b1;
                        t_len   <= f50_q ? TW'(CONV50_CYC) : TW'(CONV60_CYC);
                        step    <= ST_CONV;
                    end
                    ST_RES_RD: begin
                        rtd_code <= x_rdata[15:1];
                        step     <= ST_OFF_RD;
                    end
                    ST_OFF_RD: step <= ST_OFF_WR;
                    ST_OFF_WR: begin
                        rtd_valid <= 1'b1;
                        done      <= 1'b1;
                        step      <= ST_IDLE;
                    end
                    ST_FLT_RD: begin
                        ovuv_fault <= x_rdata[BIT_OVUV];
                        done       <= 1'b1;
                        step       <= ST_IDLE;
                    end
                    default: step <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rtd_seq_chk.sv
// Temporal checks on the sequencer's ports, attached to every instance by bind.
module rtd_seq_chk #(
    parameter bit CPOL = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        rtd_valid,
    input logic [14:0] rtd_code,
    input logic        spi_cs_n,
    input logic        spi_sclk
);

    assert_sclk_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sclk == CPOL))
        else $error("SCLK not at rest level while deselected");

    assert_cs_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy)
        else $error("select low while idle");

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)))
        else $error("done not aligned with busy falling");

    assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rtd_valid && !busy) |=> $stable(rtd_code))
        else $error("result changed while valid and idle");

endmodule

bind rtd_seq_top rtd_seq_chk #(.CPOL(CPOL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rtd_valid (rtd_valid),
    .rtd_code  (rtd_code),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk)
);

// File: tb/rtd_seq_top_test.sv
// Bench: behavioural converter model in mode 1, a vector table of result words,
// then directed tests for reset, start-up, busy triggers, fault read and 50 Hz timing.
module rtd_seq_top_test;

    localparam int SETTLE_CYC = 30;
    localparam int CONV50_CYC = 90;
    localparam int CONV60_CYC = 50;

    localparam logic [31:0] VEC [6] = '{
        {16'h0000, 16'h0000}, {16'hFFFF, 16'h7FFF}, {16'h8001, 16'h4000},
        {16'h1234, 16'h091A}, {16'hABCD, 16'h55E6}, {16'h7FFE, 16'h3FFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_three_wire = 1'b1;
    logic        cfg_filter_50 = 1'b0;
    logic        meas_start = 1'b0;
    logic        fault_start = 1'b0;
    logic        busy, done, rtd_valid, ovuv_fault;
    logic [14:0] rtd_code;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int nchk = 0;
    int nbad = 0;
    int cyc = 0;
    int ndone = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && done) ndone++;

    rtd_seq_top #(
        .CYC_PER_US(1), .SETTLE_US(SETTLE_CYC), .CONV50_US(CONV50_CYC),
        .CONV60_US(CONV60_CYC), .HALF_PER(2), .CPOL(1'b0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_three_wire(cfg_three_wire),
        .cfg_filter_50(cfg_filter_50), .meas_start(meas_start),
        .fault_start(fault_start), .busy(busy), .done(done),
        .rtd_valid(rtd_valid), .rtd_code(rtd_code), .ovuv_fault(ovuv_fault),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // Converter model: registers, transfer log with cycle stamps.
    logic [7:0] sreg [8];
    int         bitcnt = 0;
    logic [7:0] ish = '0;
    logic [6:0] saddr = '0;
    logic       swr = 1'b0;
    bit         in_tx = 1'b0;
    int         tn = 0;
    int         bad_addr = 0;
    int         tx_start [256];
    int         tx_end [256];
    int         tx_nb [256];
    logic [6:0] tx_addr [256];
    logic       tx_wr [256];
    logic [7:0] tx_data [256];

    always @(negedge spi_cs_n) if (spi_cs_n === 1'b0) begin
        in_tx = 1'b1;
        bitcnt = 0;
        tx_start[tn] = cyc;
    end

    always @(posedge spi_sclk) if (in_tx) begin
        int idx;
        idx = bitcnt / 8;
        if (idx == 0) spi_miso = 1'b0;
        else spi_miso = sreg[(int'(saddr) + idx - 1) & 7][7 - (bitcnt % 8)];
    end

    always @(negedge spi_sclk) if (in_tx) begin
        ish = {ish[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt == 8) begin
            saddr = ish[6:0];
            swr = ish[7];
            if (!(saddr inside {7'h00, 7'h01, 7'h07})) bad_addr++;
        end else if (bitcnt == 16 && swr) begin
            tx_data[tn] = ish;
            if (saddr == 7'h00) begin
                sreg[0] = ish & 8'hDD;
                if (ish[1]) sreg[7] = 8'h00;
            end
        end
    end

    always @(posedge spi_cs_n) if (in_tx) begin
        in_tx = 1'b0;
        tx_end[tn] = cyc;
        tx_addr[tn] = saddr;
        tx_wr[tn] = swr;
        tx_nb[tn] = bitcnt / 8 - 1;
        if (tn < 255) tn++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual='h%0h expected='h%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit m, input bit f);
        @(negedge clk);
        meas_start = m;
        fault_start = f;
        @(negedge clk);
        meas_start = 1'b0;
        fault_start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk(1'b0, "R7 done timeout", 0, 1);
    endtask

    task automatic check_meas(input int base, input bit f50);
        int gap;
        chk(tn == base + 7, "R3 transfer count", tn - base, 7);
        chk(tx_wr[base] == 1'b0 && tx_addr[base] == 7'h00, "R3 bias read", int'(tx_addr[base]), 0);
        chk(tx_wr[base+1] && tx_data[base+1][7], "R3 bias write", int'(tx_data[base+1]), 8'h80);
        gap = tx_start[base+2] - tx_end[base+1];
        chk(gap >= SETTLE_CYC, "R4 settle gap", gap, SETTLE_CYC);
        chk(tx_wr[base+3] && ((tx_data[base+3] & 8'hA2) == 8'hA2), "R3 one-shot write",
            int'(tx_data[base+3]), 8'hA2);
        gap = tx_start[base+4] - tx_end[base+3];
        if (f50) chk(gap >= CONV50_CYC, "R5 50Hz wait", gap, CONV50_CYC);
        else chk(gap >= CONV60_CYC && gap < CONV50_CYC, "R5 60Hz wait", gap, CONV60_CYC);
        chk(!tx_wr[base+4] && tx_addr[base+4] == 7'h01 && tx_nb[base+4] == 2,
            "R2 result read", int'(tx_addr[base+4]) * 16 + tx_nb[base+4], 8'h12);
        chk(tx_wr[base+6] && !tx_data[base+6][7] && !sreg[0][7], "R3 bias off",
            int'(tx_data[base+6]), 0);
        chk(sreg[7] == 8'h00, "R3 fault cleared", int'(sreg[7]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL R7 watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int base;
        for (int i = 0; i < 8; i++) sreg[i] = 8'h00;
        sreg[0] = 8'h04;
        // R10: reset state
        repeat (5) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R10 link idle in reset",
            {spi_cs_n, spi_sclk}, 2'b10);
        chk(!busy && !done && !rtd_valid, "R10 status in reset",
            {busy, done, rtd_valid}, 0);
        rst_n = 1'b1;
        // R1: start-up read-modify-write
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        chk(sreg[0] == 8'h14, "R1 config after start-up", int'(sreg[0]), 8'h14);
        chk(tn == 2 && !tx_wr[0] && tx_wr[1] && tx_nb[0] == 1, "R1 start-up transfers", tn, 2);
        chk(ndone == 0, "R7 no done for start-up", ndone, 0);

        // Vector table: result words through full measurements (R3..R6)
        foreach (VEC[k]) begin
            sreg[1] = VEC[k][31:24];
            sreg[2] = VEC[k][23:16];
            sreg[7] = 8'h04;
            base = tn;
            pulse(1'b1, 1'b0);
            @(negedge clk);
            chk(busy && !rtd_valid, "R6 valid drops on accept", {busy, rtd_valid}, 2'b10);
            wait_done();
            chk(rtd_valid && rtd_code == VEC[k][14:0], "R6 result code",
                int'(rtd_code), int'(VEC[k][14:0]));
            @(negedge clk);
            chk(!done && !busy, "R7 done single cycle", {done, busy}, 0);
            check_meas(base, 1'b0);
        end

        // R7: triggers while busy are ignored; simultaneous triggers pick measurement
        ndone = 0;
        base = tn;
        pulse(1'b1, 1'b1);
        repeat (20) @(negedge clk);
        pulse(1'b1, 1'b0);
        repeat (100) @(negedge clk);
        pulse(1'b0, 1'b1);
        wait_done();
        repeat (200) @(negedge clk);
        chk(tn == base + 7, "R7 busy triggers ignored", tn - base, 7);
        chk(ndone == 1, "R7 one done", ndone, 1);
        chk(spi_cs_n && !spi_sclk, "R9 clock at rest when idle", {spi_cs_n, spi_sclk}, 2'b10);
        chk(bad_addr == 0, "R2 addresses", bad_addr, 0);

        // R8: fault byte read
        sreg[7] = 8'h04;
        base = tn;
        pulse(1'b0, 1'b1);
        wait_done();
        chk(ovuv_fault == 1'b1, "R8 fault flag set", ovuv_fault, 1);
        chk(tn == base + 1 && tx_addr[base] == 7'h07 && !tx_wr[base] && tx_nb[base] == 1,
            "R8 fault transfer", int'(tx_addr[base]), 7);
        sreg[7] = 8'hFB;
        pulse(1'b0, 1'b1);
        wait_done();
        chk(ovuv_fault == 1'b0, "R8 fault flag clear", ovuv_fault, 0);

        // R1/R5: restart with 50 Hz and 2/4-wire
        @(negedge clk);
        rst_n = 1'b0;
        cfg_three_wire = 1'b0;
        cfg_filter_50 = 1'b1;
        sreg[0] = 8'h00;
        repeat (4) @(negedge clk);
        chk(!busy && !rtd_valid && spi_cs_n, "R10 second reset", {busy, rtd_valid, spi_cs_n}, 1);
        base = tn;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        chk(sreg[0] == 8'h01, "R1 config 50Hz", int'(sreg[0]), 8'h01);
        sreg[1] = 8'h40;
        sreg[2] = 8'h03;
        base = tn;
        pulse(1'b1, 1'b0);
        wait_done();
        chk(rtd_code == 15'h2001, "R6 result 50Hz", int'(rtd_code), 15'h2001);
        check_meas(base, 1'b1);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule